// File: doc/BRIEF.md
# Flash Controller Register Front End

This block sits between a simple word-wide register bus and the sequencing logic of an embedded flash memory controller. It holds the control word (lock, interrupt enables, page number, erase and program command bits, fast-program and start bits) and the two sticky result flags, end-of-operation and operation-error. Writes arrive with per-byte strobes, so word, half-word and byte stores update only the lanes they name.

Every control write gets one of three answers. It can complete at once. It can be stalled, with ready held low, until the controller is no longer busy. It can be refused with a bus error. The answer depends on whether a suspend has been requested and on whether a program or erase is running. A start issued while a suspend is requested completes on the bus but is parked, and the block stays busy, until the request is withdrawn. The parked operation then runs. A small internal sequencer stands in for the flash array: it finishes a started operation a parameterised number of cycles later and samples a pass/fail input at that moment.

Top module: `flash_csr_front`

## Requirements
- R1: After reset the control word reads 0xC000_0000 (address 1) and the status word reads 0 (address 0).
- R2: A write to the control word changes only the bytes whose strobe is set. Writable fields are program (bit 0), page erase (bit 1), mass erase (bit 2), page number (bits 9:3), start (bit 16), fast program (bit 18), completion interrupt enable (bit 24), error interrupt enable (bit 25) and lock (bit 31). Bit 30 always reads 1 and every other bit reads 0.
- R3: While lock (bit 31) is 1, control writes change nothing. Writing 1 to bit 31 sets lock and writing 0 leaves it unchanged. A one-cycle pulse on `unlock` clears lock.
- R4: With the suspend flag clear and the controller busy, a control write holds `ready` low until busy falls. It then completes and takes effect. The control word never changes while busy, except that start clears at completion.
- R5: With the suspend flag set and an operation running, a control write is answered with `ready` and `err` both high in the same cycle, and the write is discarded.
- R6: With the suspend flag set and the controller idle, a write that sets start completes without error, and `busy` rises and stays high while the flag remains set. A further control write in this state completes without error and changes nothing.
- R7: After `suspend_req` falls, the parked operation starts once the flag has cleared. `busy` stays high for OP_CYCLES+2 cycles counted from the cycle in which the request falls.
- R8: A start written while idle with no suspend raises `busy` for exactly OP_CYCLES cycles. Start (bit 16) reads 1 throughout and reads 0 afterwards.
- R9: Status bit 0 (end of operation) is set on a passing completion only when bit 24 of the control word is 1.
- R10: Status bit 1 (operation error) is set on a failing completion only when bit 25 of the control word is 1.
- R11: Writing 1 to status bit 0 or bit 1 with byte strobe 0 set clears that flag. Writes of 0, and writes without strobe 0, leave the flags unchanged.
- R12: The suspend flag follows `suspend_req` one cycle later and reads at status bit 18. Status bits 16 and 17 both read 1 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Register select: 0 status, 1 control |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte strobes, bit i for bits 8i+7:8i |
| rdata | output | 32 | Read data for the selected register |
| ready | output | 1 | Transfer completes this cycle |
| err | output | 1 | Transfer ends with a bus error |
| suspend_req | input | 1 | Request to suspend new program/erase operations |
| unlock | input | 1 | Pulse from the key logic that clears lock |
| op_fail | input | 1 | Result of the running operation, sampled at completion |
| busy | output | 1 | An operation is running or parked |

## Verification
The hardest case to reach is a control write that meets the suspend flag in each of its two states. It must arrive while the sequencer is still counting, which gives the error path, and again while an operation is parked, which gives silent completion. The stimulus issues a start, raises the suspend request on the very next cycle and fires the write one cycle later, well inside the run window. For the parked case it raises the request two cycles before the start write and holds it across later writes and status reads. Exact busy-cycle counts after the request drops pin down the hand-over from parked to running.

// File: rtl/flash_csr_pkg.sv
package flash_csr_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTES  = WORD_W / 8;

    // control word bit positions
    localparam int unsigned CB_PG     = 0;
    localparam int unsigned CB_PER    = 1;
    localparam int unsigned CB_MER    = 2;
    localparam int unsigned CB_PNB_LO = 3;
    localparam int unsigned CB_PNB_W  = 7;
    localparam int unsigned CB_STRT   = 16;
    localparam int unsigned CB_FSTPG  = 18;
    localparam int unsigned CB_EOPIE  = 24;
    localparam int unsigned CB_ERRIE  = 25;
    localparam int unsigned CB_OPTLK  = 30;
    localparam int unsigned CB_LOCK   = 31;

    // status word bit positions
    localparam int unsigned SB_EOP    = 0;
    localparam int unsigned SB_OPERR  = 1;
    localparam int unsigned SB_BUSY   = 16;
    localparam int unsigned SB_CFGBSY = 17;
    localparam int unsigned SB_SUSP   = 18;

    // register select values
    localparam int unsigned REG_STAT = 0;
    localparam int unsigned REG_CTRL = 1;

    localparam logic [WORD_W-1:0] CTRL_RST = 32'hC000_0000;

    localparam logic [WORD_W-1:0] PNB_FIELD =
        ((WORD_W'(1) << CB_PNB_W) - WORD_W'(1)) << CB_PNB_LO;

    // plain read/write bits (start and lock are set-only, handled apart)
    localparam logic [WORD_W-1:0] CTRL_RW =
        (WORD_W'(1) << CB_PG) | (WORD_W'(1) << CB_PER) | (WORD_W'(1) << CB_MER) |
        PNB_FIELD | (WORD_W'(1) << CB_FSTPG) |
        (WORD_W'(1) << CB_EOPIE) | (WORD_W'(1) << CB_ERRIE);

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HELD = 2'd1,
        OP_RUN  = 2'd2
    } op_state_e;

    typedef enum logic [1:0] {
        WR_DONE  = 2'd0,
        WR_STALL = 2'd1,
        WR_ERROR = 2'd2
    } wr_verdict_e;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [BYTES-1:0] strobes);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < BYTES; i++) begin
            m[i*8 +: 8] = {8{strobes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/fcf_arbiter.sv
module fcf_arbiter
    import flash_csr_pkg::*;
(
    input  logic        ctrl_wr_i,
    input  logic        susp_i,
    input  op_state_e   state_i,
    output wr_verdict_e verdict_o
);

    always_comb begin
        verdict_o = WR_DONE;
        if (ctrl_wr_i) begin
            if (susp_i && state_i == OP_RUN) begin
                verdict_o = WR_ERROR;
            end else if (!susp_i && state_i != OP_IDLE) begin
                verdict_o = WR_STALL;
            end
        end
    end

endmodule

// File: rtl/fcf_op_seq.sv
module fcf_op_seq
    import flash_csr_pkg::*;
#(
    parameter int unsigned OP_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      susp_i,
    output op_state_e state_o,
    output logic      done_o
);

    localparam int unsigned CW = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(OP_CYCLES - 1);

    op_state_e     st_q;
    logic [CW-1:0] cnt_q;

    assign state_o = st_q;
    assign done_o  = (st_q == OP_RUN) && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= OP_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                OP_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) begin
                        st_q <= susp_i ? OP_HELD : OP_RUN;
                    end
                end
                OP_HELD: begin
                    cnt_q <= '0;
                    if (!susp_i) begin
                        st_q <= OP_RUN;
                    end
                end
                OP_RUN: begin
                    if (done_o) begin
                        st_q  <= OP_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: st_q <= OP_IDLE;
            endcase
        end
    end

    // R7: a parked operation stays parked while suspend is requested
    a_r7_held_stays: assert property (@(posedge clk) disable iff (rst)
        (st_q == OP_HELD && susp_i) |=> st_q == OP_HELD);

    // R8: a start from idle always leaves idle on the next cycle
    a_r8_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        (st_q == OP_IDLE && start_i) |=> st_q != OP_IDLE);

endmodule

// File: rtl/fcf_ctrl_reg.sv
module fcf_ctrl_reg
    import flash_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              apply_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [BYTES-1:0]  be_i,
    input  logic              unlock_i,
    input  logic              op_done_i,
    output logic [WORD_W-1:0] ctrl_o,
    output logic              start_o
);

    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] ctrl_d;
    logic [WORD_W-1:0] lanes;
    logic              locked;

    assign lanes   = lane_mask(be_i);
    assign locked  = ctrl_q[CB_LOCK];
    assign start_o = apply_i && !locked && wdata_i[CB_STRT] && lanes[CB_STRT];
    assign ctrl_o  = ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (apply_i) begin
            if (!locked) begin
                ctrl_d = (ctrl_q & ~(lanes & CTRL_RW)) | (wdata_i & lanes & CTRL_RW);
                if (start_o) begin
                    ctrl_d[CB_STRT] = 1'b1;
                end
            end
            if (wdata_i[CB_LOCK] && lanes[CB_LOCK]) begin
                ctrl_d[CB_LOCK] = 1'b1;
            end
        end
        if (op_done_i) begin
            ctrl_d[CB_STRT] = 1'b0;
        end
        if (unlock_i) begin
            ctrl_d[CB_LOCK] = 1'b0;
        end
        ctrl_d[CB_OPTLK] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R3: a locked word holds still unless the key logic or a completion acts
    a_r3_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[CB_LOCK] && !unlock_i && !op_done_i) |=> ctrl_q == $past(ctrl_q));

endmodule

// File: rtl/fcf_status.sv
module fcf_status
    import flash_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done_i,
    input  logic       fail_i,
    input  logic       eopie_i,
    input  logic       errie_i,
    input  logic       clr_i,
    input  logic [1:0] clr_bits_i,
    input  logic       lane0_i,
    output logic       eop_o,
    output logic       operr_o
);

    logic eop_q;
    logic operr_q;
    logic clr_eop;
    logic clr_err;
    logic set_eop;
    logic set_err;

    assign clr_eop = clr_i && lane0_i && clr_bits_i[SB_EOP];
    assign clr_err = clr_i && lane0_i && clr_bits_i[SB_OPERR];
    assign set_eop = done_i && !fail_i && eopie_i;
    assign set_err = done_i && fail_i && errie_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            eop_q   <= 1'b0;
            operr_q <= 1'b0;
        end else begin
            if (set_eop)      eop_q <= 1'b1;
            else if (clr_eop) eop_q <= 1'b0;
            if (set_err)      operr_q <= 1'b1;
            else if (clr_err) operr_q <= 1'b0;
        end
    end

    assign eop_o   = eop_q;
    assign operr_o = operr_q;

    // R9: completion flag only rises with its enable and a passing finish
    a_r9_eop_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(eop_q) |-> $past(eopie_i && done_i && !fail_i));

    // R10: error flag only rises with its enable and a failing finish
    a_r10_err_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(operr_q) |-> $past(errie_i && done_i && fail_i));

endmodule

// File: rtl/flash_csr_front.sv
module flash_csr_front
    import flash_csr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned OP_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    output logic [31:0]       rdata,
    output logic              ready,
    output logic              err,
    input  logic              suspend_req,
    input  logic              unlock,
    input  logic              op_fail,
    output logic              busy
);

    logic        susp_q;
    logic        is_ctrl;
    logic        is_stat;
    logic        ctrl_wr;
    logic        ctrl_apply;
    logic        stat_clr;
    logic        op_start;
    logic        op_done;
    logic        eop;
    logic        operr;
    logic [31:0] ctrl_word;
    logic [31:0] stat_word;
    op_state_e   op_state;
    wr_verdict_e verdict;

    always_ff @(posedge clk) begin
        if (rst) susp_q <= 1'b0;
        else     susp_q <= suspend_req;
    end

    assign is_ctrl = (addr == ADDR_W'(REG_CTRL));
    assign is_stat = (addr == ADDR_W'(REG_STAT));
    assign ctrl_wr = req && we && is_ctrl;

    fcf_arbiter u_arb (
        .ctrl_wr_i (ctrl_wr),
        .susp_i    (susp_q),
        .state_i   (op_state),
        .verdict_o (verdict)
    );

    assign ready      = req && (verdict != WR_STALL);
    assign err        = req && (verdict == WR_ERROR);
    assign ctrl_apply = ctrl_wr && (verdict == WR_DONE) && (op_state == OP_IDLE);
    assign stat_clr   = req && we && is_stat;
    assign busy       = (op_state != OP_IDLE);

    fcf_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .apply_i   (ctrl_apply),
        .wdata_i   (wdata),
        .be_i      (be),
        .unlock_i  (unlock),
        .op_done_i (op_done),
        .ctrl_o    (ctrl_word),
        .start_o   (op_start)
    );

    fcf_op_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (op_start),
        .susp_i  (susp_q),
        .state_o (op_state),
        .done_o  (op_done)
    );

    fcf_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .done_i     (op_done),
        .fail_i     (op_fail),
        .eopie_i    (ctrl_word[CB_EOPIE]),
        .errie_i    (ctrl_word[CB_ERRIE]),
        .clr_i      (stat_clr),
        .clr_bits_i (wdata[1:0]),
        .lane0_i    (be[0]),
        .eop_o      (eop),
        .operr_o    (operr)
    );

    always_comb begin
        stat_word            = '0;
        stat_word[SB_EOP]    = eop;
        stat_word[SB_OPERR]  = operr;
        stat_word[SB_BUSY]   = busy;
        stat_word[SB_CFGBSY] = busy;
        stat_word[SB_SUSP]   = susp_q;
    end

    always_comb begin
        if (is_ctrl)      rdata = ctrl_word;
        else if (is_stat) rdata = stat_word;
        else              rdata = '0;
    end

    // R5: an error response is always a completed transfer
    a_r5_err_with_ready: assert property (@(posedge clk) disable iff (rst)
        err |-> ready);

    // R4: no control write completes while busy without a suspend request
    a_r4_stall_while_busy: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !susp_q && op_state != OP_IDLE) |-> !ready);

    // R4: the control word is frozen while busy (start clears only at the finish)
    a_r4_frozen_when_busy: assert property (@(posedge clk) disable iff (rst)
        (op_state != OP_IDLE && !op_done && !unlock) |=> ctrl_word == $past(ctrl_word));

    // R8: start reads 1 for as long as an operation is running or parked
    a_r8_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        (op_state != OP_IDLE) |-> ctrl_word[CB_STRT]);

    // R12: the suspend flag follows the request one cycle later
    a_r12_susp_follows: assert property (@(posedge clk) disable iff (rst)
        suspend_req |=> susp_q);

endmodule

// File: tb/sim_flash_csr_front.sv
`timescale 1ns/1ps
module sim_flash_csr_front;

    localparam int OPC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        ready;
    logic        err;
    logic        suspend_req = 1'b0;
    logic        unlock = 1'b0;
    logic        op_fail = 1'b0;
    logic        busy;

    always #2 clk = ~clk;

    flash_csr_front #(.ADDR_W(2), .OP_CYCLES(OPC)) u0 (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .ready(ready), .err(err),
        .suspend_req(suspend_req), .unlock(unlock), .op_fail(op_fail), .busy(busy)
    );

    typedef struct {
        logic        is_wr;
        logic        err;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected response per completed transfer
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (req && ready) begin
                n_vec++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected response: err=%0b rdata=%h expected none", err, rdata);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    if (err !== it.err || (!it.is_wr && rdata !== it.rdata)) begin
                        n_bad++;
                        $display("FAIL %s: err=%0b rdata=%h expected err=%0b rdata=%h",
                                 it.tag, err, rdata, it.err, it.rdata);
                    end
                end
            end
        end
    end

    // driver: called at a falling edge; returns at the falling edge after completion
    task automatic xfer(input logic w, input logic [1:0] a, input logic [31:0] d,
                        input logic [3:0] b, input logic e_err, input logic [31:0] e_rd,
                        input string tag, output int waits);
        exp_t it;
        it.is_wr = w; it.err = e_err; it.rdata = e_rd; it.tag = tag;
        sb.push_back(it);
        req = 1'b1; we = w; addr = a; wdata = d; be = b;
        waits = 0;
        forever begin
            #1;
            if (ready) break;
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b,
                      input string tag);
        int w;
        xfer(1'b1, a, d, b, 1'b0, '0, tag, w);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        int w;
        xfer(1'b0, a, '0, 4'hF, 1'b0, e, tag, w);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        forever begin
            #1;
            if (!busy || n > 1000) break;
            n++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int w;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(2'd1, 32'hC000_0000, "R1 ctrl reset");
        rd(2'd0, 32'h0000_0000, "R1 status reset");

        // R3 locked writes ignored, unlock clears lock
        wr(2'd1, 32'h0101_0001, 4'hF, "R3 locked write");
        rd(2'd1, 32'hC000_0000, "R3 locked word unchanged");
        #1; chk("R3 no start while locked", {31'd0, busy}, 32'd0);
        @(negedge clk);
        unlock = 1'b1; @(negedge clk); unlock = 1'b0;
        rd(2'd1, 32'h4000_0000, "R3 unlock clears bit31");

        // R2 byte lanes and reserved bits
        wr(2'd1, 32'hFFFF_FFFF, 4'b0001, "R2 lane0");
        rd(2'd1, 32'h4000_00FF, "R2 lane0 only");
        wr(2'd1, 32'hFFFF_FFFF, 4'b0010, "R2 lane1");
        rd(2'd1, 32'h4000_03FF, "R2 lane1 reserved stay 0");
        wr(2'd1, 32'h0004_0000, 4'b0100, "R2 lane2 fast program");
        rd(2'd1, 32'h4004_03FF, "R2 lane2");
        wr(2'd1, 32'h0300_0000, 4'b1000, "R2 lane3 enables");
        rd(2'd1, 32'h4304_03FF, "R2 lane3");
        wr(2'd1, 32'h0000_0000, 4'hF, "R2 clear word");
        rd(2'd1, 32'h4000_0000, "R2 cleared, lock stays 0");

        // R3 lock set by writing 1, then blocks other bits
        wr(2'd1, 32'h8000_0000, 4'b1000, "R3 set lock");
        rd(2'd1, 32'hC000_0000, "R3 lock set");
        wr(2'd1, 32'h0000_00FF, 4'b0001, "R3 write while locked");
        rd(2'd1, 32'hC000_0000, "R3 ignored while locked");
        unlock = 1'b1; @(negedge clk); unlock = 1'b0;
        rd(2'd1, 32'h4000_0000, "R3 unlocked again");

        // R8 / R9 plain start, completion flag with enable
        op_fail = 1'b0;
        wr(2'd1, 32'h0101_0001, 4'hF, "R8 start");
        count_busy(n);
        chk("R8 busy length", n, OPC);
        rd(2'd1, 32'h4100_0001, "R8 start cleared at finish");
        rd(2'd0, 32'h0000_0001, "R9 eop set with enable");

        // R11 write-one-to-clear
        wr(2'd0, 32'h0000_0002, 4'b0001, "R11 clear other bit");
        rd(2'd0, 32'h0000_0001, "R11 eop kept");
        wr(2'd0, 32'h0000_0001, 4'b0010, "R11 wrong lane");
        rd(2'd0, 32'h0000_0001, "R11 eop kept without lane0");
        wr(2'd0, 32'h0000_0001, 4'b0001, "R11 clear eop");
        rd(2'd0, 32'h0000_0000, "R11 eop cleared");

        // R9 no flag without enable
        wr(2'd1, 32'h0001_0001, 4'hF, "R9 start without enable");
        count_busy(n);
        rd(2'd0, 32'h0000_0000, "R9 eop stays 0 without enable");

        // R10 error flag with and without enable
        op_fail = 1'b1;
        wr(2'd1, 32'h0001_0002, 4'hF, "R10 failing op no enable");
        count_busy(n);
        rd(2'd0, 32'h0000_0000, "R10 no error flag without enable");
        wr(2'd1, 32'h0201_0002, 4'hF, "R10 failing op with enable");
        count_busy(n);
        rd(2'd0, 32'h0000_0002, "R10 error flag set");
        wr(2'd0, 32'h0000_0002, 4'b0001, "R11 clear error flag");
        rd(2'd0, 32'h0000_0000, "R11 error flag cleared");
        op_fail = 1'b0;

        // R4 stall: second write right behind the start
        wr(2'd1, 32'h0101_0001, 4'hF, "R4 start");
        xfer(1'b1, 2'd1, 32'h0100_0004, 4'hF, 1'b0, '0, "R4 stalled write", w);
        chk("R4 stall cycles", w, OPC);
        rd(2'd1, 32'h4100_0004, "R4 write applied after stall");
        rd(2'd0, 32'h0000_0001, "R4 op finished during stall");
        wr(2'd0, 32'h0000_0001, 4'b0001, "R11 clear eop");

        // R5 error while suspend requested and running
        wr(2'd1, 32'h0001_0001, 4'hF, "R5 start");
        suspend_req = 1'b1;
        @(negedge clk);
        xfer(1'b1, 2'd1, 32'h0100_0004, 4'hF, 1'b1, '0, "R5 error response", w);
        chk("R5 no wait on error", w, 0);
        rd(2'd1, 32'h4001_0001, "R5 write discarded");
        rd(2'd0, 32'h0007_0000, "R12 busy, cfg busy and suspend bits");
        suspend_req = 1'b0;
        count_busy(n);
        rd(2'd1, 32'h4000_0001, "R5 op completed");

        // R12 flag timing, R6 parked start
        addr = 2'd0;
        suspend_req = 1'b1;
        #1; chk("R12 flag not yet set", {31'd0, rdata[18]}, 32'd0);
        @(negedge clk);
        #1; chk("R12 flag set one cycle later", {31'd0, rdata[18]}, 32'd1);
        @(negedge clk);
        xfer(1'b1, 2'd1, 32'h0101_0002, 4'hF, 1'b0, '0, "R6 parked start", w);
        chk("R6 start completes at once", w, 0);
        repeat (20) @(negedge clk);
        #1; chk("R6 busy held while suspended", {31'd0, busy}, 32'd1);
        @(negedge clk);
        xfer(1'b1, 2'd1, 32'h0000_0004, 4'hF, 1'b0, '0, "R6 write while parked", w);
        chk("R6 parked write no wait", w, 0);
        rd(2'd1, 32'h4101_0002, "R6 parked write no effect");
        rd(2'd0, 32'h0007_0000, "R6 status while parked");

        // R7 release
        suspend_req = 1'b0;
        count_busy(n);
        chk("R7 busy after release", n, OPC + 2);
        rd(2'd0, 32'h0000_0001, "R7 parked op completed");
        rd(2'd1, 32'h4100_0002, "R7 start cleared");

        chk("scoreboard drained", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule